// File: doc/BRIEF.md
# Banked Scratchpad Lane Read/Write Scheduler

This block controls one lane of on-chip scratchpad memory built from eight single-ported SRAM modules. Reads and writes arrive on two separate request channels. Each channel has a valid/ready handshake and carries a word address, and the write channel also carries its data. Read data comes back on its own return channel. Each cycle the scheduler can accept one read and one write together, provided they land in different modules. The aim is to move close to twice the traffic of a single shared port.

Reads have priority. When a read and a write want the same module, the read proceeds and the write waits. A write that shares its cycle with a read leaves a one-cycle write bubble behind it. Writes that arrive while no reads are active stream back to back. A write that keeps losing is forced through after a fixed number of lost cycles. Three free-running counters record accepted reads, accepted writes and module-conflict cycles, so that throughput can be measured.

Top module: `spad_lane_sched`

## Requirements
- R1: The module index of a request is word-address bits [2:0]. The remaining upper bits select the row inside that module. Addresses that differ only above bit 2 therefore collide, and consecutive addresses rotate through all eight modules.
- R2: A read and a write to different modules are both accepted in the same cycle (rd_ready and wr_ready high), unless a write bubble (R4) or a forced write (R6) applies.
- R3: When a read and a write target the same module, including the same address, the read is accepted and wr_ready is low. A read accepted in the same cycle as a blocked write to its address returns the data that was stored before that write.
- R4: In the cycle after a write was accepted alongside a read, wr_ready is low (write bubble). rd_ready stays high in that cycle.
- R5: While no read is requested and no bubble is pending, wr_ready is high every cycle, so writes stream back to back.
- R6: After 4 consecutive cycles in which wr_valid was high and the write was not accepted, the next cycle has wr_ready high. A read to that same module is then held with rd_ready low.
- R7: Read data appears on rdata with rdata_valid high exactly two cycles after the read is accepted, in acceptance order. The value is the last write to that address accepted in an earlier cycle.
- R8: cnt_rd and cnt_wr each increase by one per accepted read or write. cnt_stall increases by one in every cycle in which rd_valid and wr_valid are both high and target the same module.
- R9: After reset, rdata_valid is low, all three counters are zero, no bubble or starvation is pending, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle when valid |
| rd_addr | input | ADDR_W | Read word address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle when valid |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rdata_valid | output | 1 | Read data strobe |
| rdata | output | DATA_W | Read data |
| cnt_rd | output | CNT_W | Accepted read count |
| cnt_wr | output | CNT_W | Accepted write count |
| cnt_stall | output | CNT_W | Module-conflict cycle count |

## Verification
The bench uses the default parameters: a 10-bit address, eight modules of 128 rows, a 32-bit data word, a starvation limit of 4 and 16-bit counters. Random addresses are confined to the first 32 words, which is four rows per module. Module collisions, exact same-address collisions and the five-cycle path to a forced write are therefore frequent and not rare events. The 16-bit counters do not wrap within the run, so every cycle's count compares exactly against the bench's own tally.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // Per-module access command for one cycle
  typedef struct packed {
    logic en;
    logic we;
  } bank_op_t;

  // At most one of rd_hit / wr_hit is high for a module in a cycle
  function automatic bank_op_t bank_op(input logic rd_hit, input logic wr_hit);
    bank_op_t op;
    op.en = rd_hit | wr_hit;
    op.we = wr_hit;
    return op;
  endfunction
endpackage

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int ROW_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  spad_pkg::bank_op_t op,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ROW_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (op.en) begin
      if (op.we) mem[row] <= wdata;
      else       rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/spad_arbiter.sv
module spad_arbiter #(
  parameter int BANK_BITS    = 3,
  parameter int STARVE_LIMIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  input  logic [BANK_BITS-1:0] rd_bank,
  input  logic                 wr_valid,
  input  logic [BANK_BITS-1:0] wr_bank,
  output logic                 rd_ready,
  output logic                 wr_ready,
  output logic                 same_bank,
  output logic                 bubble,
  output logic                 wr_forced
);
  localparam int SW = $clog2(STARVE_LIMIT + 1);

  logic [SW-1:0] starve_q;
  logic          bubble_q;
  logic          rd_fire, wr_fire, rd_blocks_wr;

  assign rd_blocks_wr = rd_valid && (rd_bank == wr_bank);
  assign same_bank    = wr_valid && rd_blocks_wr;
  assign wr_forced    = (starve_q == SW'(STARVE_LIMIT));
  assign bubble       = bubble_q;
  assign wr_ready     = wr_forced || (!bubble_q && !rd_blocks_wr);
  assign rd_ready     = !(wr_forced && same_bank);
  assign rd_fire      = rd_valid && rd_ready;
  assign wr_fire      = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bubble_q <= 1'b0;
      starve_q <= '0;
    end else begin
      bubble_q <= rd_fire && wr_fire;
      if (wr_valid && !wr_fire)
        starve_q <= wr_forced ? starve_q : starve_q + SW'(1);
      else
        starve_q <= '0;
    end
  end
endmodule

// File: rtl/spad_perf_counters.sv
module spad_perf_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic             wr_fire,
  input  logic             conflict,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] cnt_wr,
  output logic [CNT_W-1:0] cnt_stall
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_rd    <= '0;
      cnt_wr    <= '0;
      cnt_stall <= '0;
    end else begin
      if (rd_fire)  cnt_rd    <= cnt_rd + CNT_W'(1);
      if (wr_fire)  cnt_wr    <= cnt_wr + CNT_W'(1);
      if (conflict) cnt_stall <= cnt_stall + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spad_lane_sched.sv
module spad_lane_sched #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter int BANK_BITS    = 3,
  parameter int STARVE_LIMIT = 4,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [CNT_W-1:0]  cnt_wr,
  output logic [CNT_W-1:0]  cnt_stall
);
  localparam int NUM_BANKS = 2 ** BANK_BITS;
  localparam int ROW_W     = ADDR_W - BANK_BITS;

  // Named internal events
  logic                 rd_fire, wr_fire, same_bank, bubble, wr_forced;
  logic [BANK_BITS-1:0] rd_bank, wr_bank, rd_bank_q;
  logic [ROW_W-1:0]     rd_row, wr_row;
  logic                 rd_stage1;
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

  // R1: module select from low word-address bits
  assign rd_bank = rd_addr[BANK_BITS-1:0];
  assign wr_bank = wr_addr[BANK_BITS-1:0];
  assign rd_row  = rd_addr[ADDR_W-1:BANK_BITS];
  assign wr_row  = wr_addr[ADDR_W-1:BANK_BITS];

  spad_arbiter #(.BANK_BITS(BANK_BITS), .STARVE_LIMIT(STARVE_LIMIT)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_bank(rd_bank),
    .wr_valid(wr_valid), .wr_bank(wr_bank),
    .rd_ready(rd_ready), .wr_ready(wr_ready),
    .same_bank(same_bank), .bubble(bubble), .wr_forced(wr_forced)
  );

  assign rd_fire = rd_valid && rd_ready;
  assign wr_fire = wr_valid && wr_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic rd_hit, wr_hit;
    assign rd_hit = rd_fire && (rd_bank == BANK_BITS'(b));
    assign wr_hit = wr_fire && (wr_bank == BANK_BITS'(b));
    spad_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk),
      .op(spad_pkg::bank_op(rd_hit, wr_hit)),
      .row(rd_hit ? rd_row : wr_row),
      .wdata(wr_data),
      .rdata(bank_rdata[b])
    );
  end

  // Two-stage return: module array register, then output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_stage1   <= 1'b0;
      rdata_valid <= 1'b0;
    end else begin
      rd_stage1   <= rd_fire;
      rdata_valid <= rd_stage1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire)   rd_bank_q <= rd_bank;
    if (rd_stage1) rdata     <= bank_rdata[rd_bank_q];
  end

  spad_perf_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .conflict(same_bank),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_stall(cnt_stall)
  );
endmodule

module spad_lane_sched_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             same_bank,
  input logic             bubble,
  input logic             wr_forced,
  input logic             rdata_valid,
  input logic [CNT_W-1:0] cnt_rd
);
  logic rd_fire, wr_fire;
  assign rd_fire = rd_valid && rd_ready;
  assign wr_fire = wr_valid && wr_ready;

  p_pair_distinct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && wr_fire) |-> !same_bank);
  p_pair_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && wr_valid && !same_bank && !bubble) |-> (rd_ready && wr_ready));
  p_read_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (same_bank && !wr_forced) |-> (rd_ready && !wr_ready));
  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && wr_fire) |=> (!wr_ready && rd_ready));
  p_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !bubble) |-> wr_ready);
  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_forced && same_bank) |-> (wr_ready && !rd_ready));
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ##1 rdata_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(rd_fire, 2));
  p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (cnt_rd == $past(cnt_rd) + CNT_W'(1)));
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(cnt_rd));
endmodule

bind spad_lane_sched spad_lane_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .same_bank(same_bank), .bubble(bubble), .wr_forced(wr_forced),
  .rdata_valid(rdata_valid), .cnt_rd(cnt_rd)
);

// File: tb/spad_lane_sched_bench.sv
`timescale 1ns/1ps
module spad_lane_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0, wr_valid = 1'b0;
  logic        rd_ready, wr_ready, rdata_valid;
  logic [9:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0, rdata;
  logic [15:0] cnt_rd, cnt_wr, cnt_stall;

  always #2 clk = ~clk;  // 250 MHz

  spad_lane_sched u_spad_lane_sched (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rdata_valid(rdata_valid), .rdata(rdata),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_stall(cnt_stall)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model state
  logic [31:0] m_mem [1024];
  bit          m_bubble = 0;
  int          m_starve = 0;
  bit          m_v1 = 0, m_v2 = 0;
  logic [31:0] m_d1 = '0, m_d2 = '0;
  int          m_crd = 0, m_cwr = 0, m_cst = 0;
  bit          last_rf, last_wf;

  function automatic int module_of(input int a); return a % 8; endfunction
  function automatic logic [31:0] init_word(input int a);
    return (a * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit rv, input int ra, input bit wv, input int wa,
                      input logic [31:0] wd);
    bit e_rd, e_wr, force_w, conf;
    string tag;
    @(negedge clk);
    check(rdata_valid === m_v2, "R7 rdata_valid", rdata_valid, m_v2);
    if (m_v2) check(rdata === m_d2, "R7 rdata", rdata, m_d2);
    check(cnt_rd === 16'(m_crd), "R8 cnt_rd", cnt_rd, m_crd);
    check(cnt_wr === 16'(m_cwr), "R8 cnt_wr", cnt_wr, m_cwr);
    check(cnt_stall === 16'(m_cst), "R8 cnt_stall", cnt_stall, m_cst);
    rd_valid = rv; rd_addr = 10'(ra); wr_valid = wv; wr_addr = 10'(wa); wr_data = wd;
    #1;
    force_w = (m_starve >= 4);
    conf    = rv && wv && module_of(ra) == module_of(wa);
    e_wr = force_w || (!m_bubble && !(rv && module_of(ra) == module_of(wa)));
    e_rd = !(force_w && conf);
    if (force_w)              tag = "R6 forced write";
    else if (conf)            tag = "R1/R3 module conflict";
    else if (m_bubble)        tag = "R4 write bubble";
    else if (rv)              tag = "R2 paired issue";
    else                      tag = "R5 write stream";
    check(rd_ready === e_rd, {tag, " rd_ready"}, rd_ready, e_rd);
    check(wr_ready === e_wr, {tag, " wr_ready"}, wr_ready, e_wr);
    @(posedge clk);
    last_rf = rv && e_rd;
    last_wf = wv && e_wr;
    m_v2 = m_v1; m_d2 = m_d1;
    m_v1 = last_rf;
    if (last_rf) m_d1 = m_mem[ra];
    if (last_wf) m_mem[wa] = wd;
    m_starve = (wv && !last_wf) ? ((m_starve < 4) ? m_starve + 1 : 4) : 0;
    m_bubble = last_rf && last_wf;
    m_crd += int'(last_rf);
    m_cwr += int'(last_wf);
    m_cst += int'(conf);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit p_rv, p_wv;
    int p_ra, p_wa, ra;
    logic [31:0] p_wd;
    void'($urandom(32'd20240611));
    foreach (m_mem[i]) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: reset state
    #1;
    check(rdata_valid === 1'b0, "R9 rdata_valid", rdata_valid, 0);
    check(cnt_rd === 0 && cnt_wr === 0 && cnt_stall === 0, "R9 counters",
          {cnt_rd, cnt_wr, cnt_stall}, 0);
    check(rd_ready === 1'b1, "R9 rd_ready", rd_ready, 1);
    check(wr_ready === 1'b1, "R9 wr_ready", wr_ready, 1);

    // R5: fill words 0..31 back to back, no reads
    for (int a = 0; a < 32; a++) step(0, 0, 1, a, init_word(a));
    // R2 then R4: pair, then bubble on the next write
    step(1, 1, 1, 2, 32'h1111_2222);
    step(1, 3, 1, 4, 32'h3333_4444);
    step(0, 0, 1, 4, 32'h3333_4444);
    // R3: same address; read gets old data, write follows
    step(1, 5, 1, 5, 32'hDEAD_BEEF);
    step(0, 0, 1, 5, 32'hDEAD_BEEF);
    step(1, 5, 0, 0, 0);
    // R6: reads hammer module 6 until the write is forced
    ra = 14;
    do begin
      step(1, ra, 1, 6, 32'h6666_0006);
      if (last_rf) ra = (ra + 8) % 32;
    end while (!last_wf);
    repeat (4) step(0, 0, 0, 0, 0);

    // Constrained random traffic over words 0..31
    p_rv = 0; p_wv = 0; p_ra = 0; p_wa = 0; p_wd = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!p_rv || last_rf) begin
        p_rv = ($urandom % 4) != 0; p_ra = $urandom % 32;
      end
      if (!p_wv || last_wf) begin
        p_wv = ($urandom % 3) != 0; p_wa = $urandom % 32; p_wd = $urandom;
      end
      step(p_rv, p_ra, p_wv, p_wa, p_wd);
    end
    repeat (4) step(0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule